// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

This block is a free-running 16-bit time base for a larger peripheral. Each cycle it picks one of four clock-enable tick lines. It divides the selected ticks by 1, 2, 4 or 8 and advances its count by one step for each divided tick. A two-bit mode field chooses how the count moves. It can hold still, climb to a period value and restart, run over the whole 16-bit range, or climb to the period and fall back to zero. The period comes from the capture/compare channel 0 compare value, which this block receives as a plain input.

A one-cycle clear strobe returns the count, the direction and the prescaler phase to zero. The strobe stores nothing. Every wrap of the count to zero sets an overflow flag, and so does the arrival at zero on the falling leg of up/down mode. The flag stays set until an acknowledge pulse removes it. The flag is gated by an enable to form the interrupt request. The count and the present direction are outputs, so that compare channels and output units can be attached later.

Top module: `tmr_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (rising), and the overflow flag and interrupt request are both 0.
- R2: Mode code 00 stops the counter. The count and the prescaler phase hold, selected ticks are ignored, and the direction is kept. Leaving code 00 continues from the held count in the held direction.
- R3: Mode code 01 (up) steps 0, 1, … up to the period value and then returns to 0. With period 0 the count stays at 0 and every step is a wrap.
- R4: Mode code 10 (continuous) steps by one on every divided tick, from 0 to 0xFFFF, and wraps to 0.
- R5: Mode code 11 (up/down) climbs from 0 to the period and then descends to 0, and this repeats. The direction output is 1 while the next step goes down. It changes on the step that reaches the period and on the step that reaches 0.
- R6: Divider code 00/01/10/11 makes one step per 1/2/4/8 selected ticks. After a clear, the first step falls on the last tick of a full group.
- R7: The select field is a binary index into the four tick lines. Ticks on the lines that are not selected have no effect.
- R8: A clear strobe in a cycle sets the count to 0, the direction to rising and the prescaler phase to 0 at the next edge. It wins over a simultaneous step, and it has no effect after its cycle.
- R9: The overflow flag is set when the count wraps to 0 in up or continuous mode, and when it reaches 0 going down in up/down mode. It holds until an acknowledge pulse. A set in the same cycle as the acknowledge wins.
- R10: The interrupt request is 1 exactly when the overflow flag is 1 and the enable input is 1.
- R11: In up mode, if the period is below the current count, the count runs on to 0xFFFF, wraps to 0 with the overflow flag set, and then obeys the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | Clock-enable tick lines, one per source |
| src_sel_i | input | 2 | Index of the tick line in use |
| div_sel_i | input | 2 | Prescaler code: 00 /1, 01 /2, 10 /4, 11 /8 |
| mode_i | input | 2 | Count mode: 00 stop, 01 up, 10 continuous, 11 up/down |
| clr_i | input | 1 | One-cycle clear strobe for count, direction and prescaler |
| period_i | input | 16 | Period value taken from channel 0 |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_ack_i | input | 1 | Pulse that clears the overflow flag |
| count_o | output | 16 | Present count |
| cnt_down_o | output | 1 | 1 while the counter is on the falling leg |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Several rules are checked by the assertions on every cycle. They check that stop mode freezes the count and the prescaler phase, and that a clear zeroes both. They check that continuous mode advances by exactly one, that the falling leg of up/down mode drops by exactly one, and that up mode restarts at the period. They also check that a wrap always leaves the flag set, that an unacknowledged flag persists, and that the request stays low while disabled. Other behaviours need whole sequences, and only the bench's scenarios show them. These are the full up/down turnaround with its direction changes, the step spacing under each divider code, the tick lines that are ignored, resumption from stop with the direction kept, the set-beats-acknowledge race, and the long run past a period lowered under the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NSRC  = 4,
  parameter int DIV_W = 2,
  localparam int SEL_W = $clog2(NSRC),
  localparam int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_tick_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             tick;

  assign tick = src_tick_i[src_sel_i];

  // thermometer mask: /2^k needs k low phase bits all ones
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = (32'(div_sel_i) > g);
  end

  assign step_o = run_i && tick && !clr_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (clr_i)         pre_q <= '0;
    else if (run_i && tick) pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0); // R8
  AST_PRE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pre_q)); // R2
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_mode_e        mode_i,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      dir_d = 1'b0;
    end else if (step_i) begin
      unique case (mode_i)
        MODE_UP: begin
          dir_d = 1'b0;
          if (cnt_q == period_i || cnt_q == MAX) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_CONT: begin
          dir_d = 1'b0;
          cnt_d = cnt_q + ONE;
          wrap  = (cnt_q == MAX);
        end
        MODE_UPDN: begin
          if (!dir_q) begin
            if (cnt_q < period_i) begin
              cnt_d = cnt_q + ONE;
              dir_d = ((cnt_q + ONE) == period_i);
            end else if (cnt_q != '0) begin
              // period lowered under count: turn and descend
              cnt_d = cnt_q - ONE;
              dir_d = (cnt_q != ONE);
              wrap  = (cnt_q == ONE);
            end
          end else if (cnt_q <= ONE) begin
            cnt_d = '0;
            dir_d = 1'b0;
            wrap  = (cnt_q == ONE);
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count_o = cnt_q;
  assign down_o  = dir_q;
  assign wrap_o  = wrap;

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !clr_i) |=> ($stable(cnt_q) && $stable(dir_q))); // R2
  AST_CONT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && step_i && !clr_i) |=> cnt_q == CNT_W'($past(cnt_q) + ONE)); // R4
  AST_UP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && step_i && !clr_i && cnt_q == period_i) |=> cnt_q == '0); // R3
  AST_UD_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UPDN && step_i && !clr_i && dir_q && cnt_q > ONE)
      |=> cnt_q == CNT_W'($past(cnt_q) - ONE)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dir_q)); // R8
endmodule

// File: rtl/tmr_ovf.sv
module tmr_ovf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= wrap_i | (flag_q & ~ack_i);
  end

  assign flag_o = flag_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q); // R9
  AST_OVF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q); // R9
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NSRC  = 4,
  parameter int DIV_W = 2,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_tick_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [1:0]       mode_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             ovf_ie_i,
  input  logic             ovf_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cnt_down_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  tmr_mode_e mode;
  logic      step;
  logic      wrap;
  logic      flag;

  assign mode = tmr_mode_e'(mode_i);

  tmr_prescale #(.NSRC(NSRC), .DIV_W(DIV_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (src_tick_i),
    .src_sel_i  (src_sel_i),
    .div_sel_i  (div_sel_i),
    .run_i      (mode != MODE_STOP),
    .clr_i      (clr_i),
    .step_o     (step)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .step_i   (step),
    .clr_i    (clr_i),
    .period_i (period_i),
    .count_o  (count_o),
    .down_o   (cnt_down_o),
    .wrap_o   (wrap)
  );

  tmr_ovf u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .ack_i  (ovf_ack_i),
    .flag_o (flag)
  );

  assign ovf_flag_o = flag;
  assign irq_o      = flag & ovf_ie_i;

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_ie_i |-> !irq_o); // R10
endmodule

// File: tb/tmr_counter_bench.sv
module tmr_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic [1:0]  sel = '0;
  logic [1:0]  dsel = '0;
  logic [1:0]  mode = '0;
  logic        clr = 1'b0;
  logic [15:0] per = '0;
  logic        ie = 1'b0;
  logic        ack = 1'b0;
  logic [15:0] count;
  logic        down, flag, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_dir = 0, m_flag = 0, m_pre = 0;

  always #2 clk = ~clk;

  tmr_counter u_tmr_counter (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .src_sel_i(sel),
    .div_sel_i(dsel), .mode_i(mode), .clr_i(clr), .period_i(per),
    .ovf_ie_i(ie), .ovf_ack_i(ack), .count_o(count), .cnt_down_o(down),
    .ovf_flag_o(flag), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_flag = 0; m_pre = 0;
    end else begin
      int grp, p;
      bit stp, hit;
      grp = 1 << dsel;
      p = int'(per);
      hit = 0;
      stp = 0;
      if (ack) m_flag = 0;
      if (clr) begin
        m_cnt = 0; m_dir = 0; m_pre = 0;
      end else if (mode != 2'b00 && src[sel]) begin
        stp = (m_pre % grp) == grp - 1;
        m_pre = (m_pre + 1) % 8;
      end
      if (stp) begin
        case (mode)
          2'b01: begin
            m_dir = 0;
            if (m_cnt == p || m_cnt == 65535) begin m_cnt = 0; hit = 1; end
            else m_cnt++;
          end
          2'b10: begin
            m_dir = 0;
            if (m_cnt == 65535) begin m_cnt = 0; hit = 1; end
            else m_cnt++;
          end
          2'b11: begin
            if (m_dir == 0) begin
              if (m_cnt < p) begin
                m_cnt++;
                if (m_cnt == p) m_dir = 1;
              end else if (m_cnt > 0) begin
                m_cnt--;
                m_dir = 1;
                if (m_cnt == 0) begin m_dir = 0; hit = 1; end
              end
            end else begin
              if (m_cnt <= 1) begin
                if (m_cnt == 1) hit = 1;
                m_cnt = 0; m_dir = 0;
              end else m_cnt--;
            end
          end
          default: ;
        endcase
      end
      if (hit) m_flag = 1;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(count) != m_cnt || int'(down) != m_dir || int'(flag) != m_flag ||
          irq != (m_flag[0] & ie)) begin
        n_fail++;
        $display("FAIL %s: cnt/dir/flag/irq got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 cur_req, count, down, flag, irq, m_cnt, m_dir, m_flag, m_flag[0] & ie);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    cur_req = "R1";
    chk("R1 count", count, 0); chk("R1 dir", down, 0);
    chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);

    // R4 continuous, every tick
    cur_req = "R4";
    src = 4'b0001; sel = 2'd0; dsel = 2'd0; mode = 2'b10;
    cyc(20);
    chk("R4 count after 20", count, 20);

    // R8 clear resets, then counting resumes
    cur_req = "R8";
    pulse_clr();
    chk("R8 count after clear", count, 0);
    cyc(3);
    chk("R8 clear is one-shot", count, 3);

    // R4 full wrap
    cur_req = "R4";
    pulse_clr();
    cyc(65535);
    chk("R4 count at max", count, 65535);
    chk("R4 no flag before wrap", flag, 0);
    cyc(1);
    chk("R4 wrap to 0", count, 0);
    chk("R9 flag on wrap", flag, 1);
    // R10 irq gating
    cur_req = "R10";
    chk("R10 irq disabled", irq, 0);
    ie = 1'b1; cyc(1);
    chk("R10 irq enabled", irq, 1);
    cur_req = "R9";
    cyc(3);
    chk("R9 flag held", flag, 1);
    pulse_ack();
    chk("R9 flag cleared", flag, 0);
    chk("R10 irq drops", irq, 0);

    // R3 up mode period 5
    cur_req = "R3";
    mode = 2'b00; per = 16'd5; pulse_clr();
    mode = 2'b01;
    cyc(5);
    chk("R3 count at period", count, 5);
    cyc(1);
    chk("R3 restart", count, 0);
    chk("R9 up wrap flag", flag, 1);
    cyc(2);
    chk("R3 second pass", count, 2);
    pulse_ack();

    // R9 set wins over ack: up mode with period 0 wraps every step
    cur_req = "R9";
    per = 16'd0; pulse_clr();
    cyc(2);
    chk("R3 period 0 holds 0", count, 0);
    pulse_ack();
    chk("R9 set beats ack", flag, 1);
    mode = 2'b00;
    pulse_ack();
    chk("R9 ack in stop", flag, 0);

    // R5 up/down period 3
    cur_req = "R5";
    per = 16'd3; pulse_clr(); mode = 2'b11;
    cyc(3);
    chk("R5 top", count, 3); chk("R5 dir down at top", down, 1);
    cyc(1);
    chk("R5 falling", count, 2);
    // R2 stop in the falling leg, direction kept
    cur_req = "R2";
    mode = 2'b00;
    cyc(10);
    chk("R2 held count", count, 2); chk("R2 held dir", down, 1);
    mode = 2'b11;
    cyc(1);
    chk("R2 resume down", count, 1);
    cur_req = "R5";
    cyc(1);
    chk("R5 bottom", count, 0); chk("R5 dir up at bottom", down, 0);
    chk("R9 updown flag", flag, 1);
    cyc(1);
    chk("R5 climbs again", count, 1);
    pulse_ack();

    // R6 divider /4 with a tick every other cycle on line 1
    cur_req = "R6";
    mode = 2'b00; sel = 2'd1; dsel = 2'd2; pulse_clr();
    mode = 2'b10;
    for (int i = 0; i < 8; i++) begin
      src = 4'b0010; cyc(1); src = 4'b0000; cyc(1);
    end
    chk("R6 /4 eight ticks", count, 2);
    dsel = 2'd3; mode = 2'b00; pulse_clr(); mode = 2'b10;
    src = 4'b0010;
    cyc(7);
    chk("R6 /8 before group end", count, 0);
    cyc(1);
    chk("R6 /8 step", count, 1);
    dsel = 2'd1; pulse_clr();
    cyc(6);
    chk("R6 /2", count, 3);

    // R7 unselected lines ignored
    cur_req = "R7";
    dsel = 2'd0; sel = 2'd2; pulse_clr();
    src = 4'b1011;
    cyc(10);
    chk("R7 other lines ignored", count, 0);
    src = 4'b0100;
    cyc(4);
    chk("R7 selected line counts", count, 4);

    // R11 period lowered under count in up mode
    cur_req = "R11";
    sel = 2'd0; src = 4'b0001; mode = 2'b01; per = 16'd100; pulse_clr();
    cyc(10);
    chk("R11 pre count", count, 10);
    per = 16'd4;
    cyc(65525);
    chk("R11 runs to max", count, 65535);
    cyc(1);
    chk("R11 wraps", count, 0);
    chk("R11 flag", flag, 1);
    cyc(5);
    chk("R11 new period honoured", count, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule